// File: doc/BRIEF.md
# Wake-Up Frame Pattern Filter

This block watches the byte stream of received Ethernet frames and flags frames that carry a programmed wake pattern. Four filters run side by side. Each filter picks up to 31 byte positions with a bit mask, counted from a programmable start offset. It runs only those bytes through its own CRC-16 engine. When a good frame ends, it compares the result with a stored expected value.

A filter can only match frames whose destination address type fits its setting, which is either unicast or multicast. It can also be switched off. Matches collect in a sticky per-filter hit vector, and the wake output is the OR of that vector. Software clears both with a single register write. The receive MAC supplies bytes starting at the first destination-address byte, together with frame start, frame end and frame-good strobes.

Top module: `wake_pattern_filter`

## Requirements
- R1: After reset `hit_o` is 0, `wake_o` is 0, and every filter is disabled with a zero mask, offset and expected value.
- R2: The byte presented with `sof_i` is position 0, and later valid bytes count up by one. Mask bit j of a filter selects position offset+j. Only selected bytes change that filter's CRC.
- R3: The CRC-16 uses polynomial 0x8005 and starts at 0xFFFF. Each byte is shifted in LSB first: feedback = crc[15] xor data bit, crc shifts left, and the polynomial is XORed in when feedback is 1.
- R4: A filter hits when `eof_i` and `good_i` are high together and four conditions hold: the filter is enabled, the address type fits, all selected positions have arrived, and its CRC equals its expected value. The hit sets its bit in `hit_o` on the clock edge that samples the strobe.
- R5: Command bit 0 enables a filter. A disabled filter never sets its hit bit.
- R6: Command bit 3 set restricts the filter to multicast frames, and clear restricts it to unicast frames. A frame is multicast when bit 0 of its position-0 byte is 1.
- R7: Command bits 2:1 and mask bit 31 are ignored. Writing them set gives the same behaviour as writing them clear.
- R8: If a frame ends before position offset+h has arrived, where h is the highest set mask bit, that filter does not hit.
- R9: An `eof_i` strobe with `good_i` low leaves `hit_o` and `wake_o` unchanged.
- R10: Hit bits are sticky, and `wake_o` is the OR of `hit_o`. A write to address 16 clears all hit bits, and this clear wins over a good end of frame in the same cycle.
- R11: Configuration addresses are byte mask 0-3, command 4-7, offset 8-11 (data bits 7:0) and expected CRC 12-15 (data bits 15:0), with the low two bits selecting the filter.
- R12: Each `sof_i` restarts every filter's CRC and the position count, including a `sof_i` that arrives in the middle of a frame with no end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | First byte of a frame, qualified by byte_vld_i |
| byte_vld_i | input | 1 | Byte valid |
| byte_i | input | 8 | Frame byte from the destination address onward |
| eof_i | input | 1 | End-of-frame strobe, in a cycle after the last byte |
| good_i | input | 1 | Frame passed FCS, qualifies eof_i |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration address |
| cfg_wdata_i | input | 32 | Configuration write data |
| wake_o | output | 1 | Wake event, OR of hit_o |
| hit_o | output | 4 | Sticky per-filter match flags |

## Verification
The bench targets the window edges of the mask. A design that is off by one in offset+j would feed the wrong byte, and a change to an unselected byte would then break a match. It also checks that bit 31 of the mask is dropped, because keeping it would widen the window. A frame that ends short of its highest selected position must not match even when the CRC over the bytes that did arrive equals the stored value; a design that skipped the completeness test would wake falsely. Further cases are the address-type gate taken from the first byte, a restart in mid-frame that must discard partial CRC state, a bad-frame end that must leave the flags alone, and a clear that coincides with a good end, where a wrong priority leaves a stale flag.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  localparam int NUM_FILT = 4;
  localparam int IDX_W    = $clog2(NUM_FILT);
  localparam int MASK_W   = 31;
  localparam int MIDX_W   = $clog2(MASK_W);
  localparam int OFS_W    = 8;
  localparam int POS_W    = OFS_W + 1;
  localparam int CRC_W    = 16;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam logic [CRC_W-1:0]  CRC_POLY = 16'h8005;
  localparam logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF;
  localparam logic [ADDR_W-1:0] CLR_ADDR = 5'h10;

  typedef enum logic [1:0] {GRP_MASK, GRP_CMD, GRP_OFS, GRP_CRC} grp_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 8; b++) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/wpf_cfg_regs.sv
module wpf_cfg_regs
  import wpf_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_FILT-1:0][MASK_W-1:0]  mask_o,
  output logic [NUM_FILT-1:0][OFS_W-1:0]   ofs_o,
  output logic [NUM_FILT-1:0][CRC_W-1:0]   crc_o,
  output logic [NUM_FILT-1:0]              en_o,
  output logic [NUM_FILT-1:0]              mc_o,
  output logic                             clr_o
);
  grp_e             grp;
  logic [IDX_W-1:0] idx;
  logic             bank_we;

  assign grp     = grp_e'(addr_i[IDX_W+1:IDX_W]);
  assign idx     = addr_i[IDX_W-1:0];
  assign bank_we = we_i && !addr_i[ADDR_W-1];
  assign clr_o   = we_i && (addr_i == CLR_ADDR);

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[i] <= '0;
        ofs_o[i]  <= '0;
        crc_o[i]  <= '0;
        en_o[i]   <= 1'b0;
        mc_o[i]   <= 1'b0;
      end else if (bank_we && idx == IDX_W'(i)) begin
        unique case (grp)
          GRP_MASK: mask_o[i] <= wdata_i[MASK_W-1:0];  // bit 31 dropped
          GRP_CMD: begin
            en_o[i] <= wdata_i[0];
            mc_o[i] <= wdata_i[3];
          end
          GRP_OFS:  ofs_o[i] <= wdata_i[OFS_W-1:0];
          GRP_CRC:  crc_o[i] <= wdata_i[CRC_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wpf_lane.sv
module wpf_lane
  import wpf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic              sof_i,
  input  logic [7:0]        byte_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [POS_W-1:0]  cnt_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [CRC_W-1:0]  exp_i,
  input  logic              en_i,
  input  logic              mc_i,
  input  logic              frame_mc_i,
  output logic              match_o
);
  function automatic logic [MIDX_W:0] mask_span(input logic [MASK_W-1:0] m);
    logic [MIDX_W:0] s;
    s = '0;
    for (int j = 0; j < MASK_W; j++) if (m[j]) s = (MIDX_W+1)'(j + 1);
    return s;
  endfunction

  logic [POS_W-1:0] ofs_ext, rel, need;
  logic [MIDX_W:0]  span;
  logic             in_win, sel, complete;
  logic [CRC_W-1:0] crc_q, crc_base, crc_d;

  assign ofs_ext = {1'b0, ofs_i};
  assign rel     = pos_i - ofs_ext;
  assign in_win  = (pos_i >= ofs_ext) && (rel < POS_W'(MASK_W));
  assign sel     = in_win && mask_i[rel[MIDX_W-1:0]];

  assign span     = mask_span(mask_i);
  assign need     = ofs_ext + POS_W'(span);
  assign complete = (span == '0) || (cnt_i >= need);

  assign crc_base = sof_i ? CRC_INIT : crc_q;
  assign crc_d    = sel ? crc_step(crc_base, byte_i) : crc_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         crc_q <= CRC_INIT;
    else if (byte_vld_i) crc_q <= crc_d;
  end

  assign match_o = en_i && (mc_i == frame_mc_i) && complete && (crc_q == exp_i);
endmodule

// File: rtl/wake_pattern_filter.sv
module wake_pattern_filter
  import wpf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sof_i,
  input  logic                byte_vld_i,
  input  logic [7:0]          byte_i,
  input  logic                eof_i,
  input  logic                good_i,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic                wake_o,
  output logic [NUM_FILT-1:0] hit_o
);
  logic [NUM_FILT-1:0][MASK_W-1:0] mask_q;
  logic [NUM_FILT-1:0][OFS_W-1:0]  ofs_q;
  logic [NUM_FILT-1:0][CRC_W-1:0]  exp_q;
  logic [NUM_FILT-1:0]             en_vec, mc_vec, match_vec;
  logic                            clr;
  logic [POS_W-1:0]                cnt_q, pos;
  logic                            frame_mc_q;
  logic                            sof_vld;

  wpf_cfg_regs u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .mask_o  (mask_q),
    .ofs_o   (ofs_q),
    .crc_o   (exp_q),
    .en_o    (en_vec),
    .mc_o    (mc_vec),
    .clr_o   (clr)
  );

  assign sof_vld = sof_i && byte_vld_i;
  assign pos     = sof_vld ? '0 : cnt_q;

  // saturating received-byte count shared by all lanes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      frame_mc_q <= 1'b0;
    end else if (byte_vld_i) begin
      if (sof_vld) begin
        cnt_q      <= POS_W'(1);
        frame_mc_q <= byte_i[0];
      end else if (!(&cnt_q)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_lane
    wpf_lane u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .byte_vld_i (byte_vld_i),
      .sof_i      (sof_vld),
      .byte_i     (byte_i),
      .pos_i      (pos),
      .cnt_i      (cnt_q),
      .mask_i     (mask_q[i]),
      .ofs_i      (ofs_q[i]),
      .exp_i      (exp_q[i]),
      .en_i       (en_vec[i]),
      .mc_i       (mc_vec[i]),
      .frame_mc_i (frame_mc_q),
      .match_o    (match_vec[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hit_o <= '0;
    else if (clr)             hit_o <= '0;
    else if (eof_i && good_i) hit_o <= hit_o | match_vec;
  end

  assign wake_o = |hit_o;
endmodule

// File: rtl/wpf_chk.sv
module wpf_chk
  import wpf_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                eof_i,
  input logic                good_i,
  input logic                cfg_we_i,
  input logic [ADDR_W-1:0]   cfg_addr_i,
  input logic [NUM_FILT-1:0] hit_o,
  input logic [NUM_FILT-1:0] en_i,
  input logic                wake_o
);
  logic clr_wr;
  assign clr_wr = cfg_we_i && (cfg_addr_i == CLR_ADDR);

  // R4
  hit_after_good_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_o & ~$past(hit_o)) != '0) |-> $past(eof_i && good_i));

  // R5
  disabled_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & ~$past(hit_o) & ~$past(en_i)) == '0);

  // R10
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (hit_o == '0) && !wake_o);

  // R10
  hit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eof_i && !clr_wr) |=> $stable(hit_o));

  // R9
  bad_eof_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && !good_i && !clr_wr) |=> $stable(hit_o) && $stable(wake_o));
endmodule

bind wake_pattern_filter wpf_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eof_i      (eof_i),
  .good_i     (good_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .hit_o      (hit_o),
  .en_i       (en_vec),
  .wake_o     (wake_o)
);

// File: tb/wake_pattern_filter_tb.sv
module wake_pattern_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, vld = 1'b0, eof = 1'b0, good = 1'b0, we = 1'b0;
  logic [7:0]  bdat = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdat = '0;
  logic        wake;
  logic [3:0]  hit;

  int n_chk = 0, n_err = 0;
  logic [7:0]  fb [0:127];
  int          flen;
  logic [30:0] s_msk [4];
  logic [7:0]  s_ofs [4];
  logic [15:0] s_crc [4];
  logic        s_en [4], s_mc [4];
  logic [3:0]  exp_hit;

  wake_pattern_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(bdat),
    .eof_i(eof), .good_i(good), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdat), .wake_o(wake), .hit_o(hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] tb_crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[15] ^ d[b]) r = (r << 1) ^ 16'h8005;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] tb_crc(input logic [30:0] m, input logic [7:0] o);
    logic [15:0] c = 16'hFFFF;
    for (int p = 0; p < flen; p++)
      if (p >= int'(o) && p - int'(o) < 31 && m[p - int'(o)]) c = tb_crc_byte(c, fb[p]);
    return c;
  endfunction

  function automatic logic [3:0] model_hits();
    logic [3:0] h = '0;
    for (int i = 0; i < 4; i++) begin
      int top = -1;
      for (int j = 0; j < 31; j++) if (s_msk[i][j]) top = j;
      h[i] = s_en[i] && (s_mc[i] == fb[0][0]) && (int'(s_ofs[i]) + top + 1 <= flen)
             && (tb_crc(s_msk[i], s_ofs[i]) == s_crc[i]);
    end
    return h;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdat = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic clear_hits();
    wr(5'd16, 32'd0);
    exp_hit = '0;
  endtask

  // R11 address map: mask 0+i, cmd 4+i, offset 8+i, crc 12+i
  task automatic cfg(input int i, input logic [31:0] m, input logic [31:0] cmd,
                     input logic [7:0] o, input logic [15:0] c);
    wr(5'(i), m); wr(5'(4 + i), cmd); wr(5'(8 + i), {24'd0, o}); wr(5'(12 + i), {16'd0, c});
    s_msk[i] = m[30:0]; s_en[i] = cmd[0]; s_mc[i] = cmd[3]; s_ofs[i] = o; s_crc[i] = c;
  endtask

  task automatic send(input logic g, input logic do_eof);
    for (int p = 0; p < flen; p++) begin
      @(negedge clk); vld = 1'b1; sof = (p == 0); bdat = fb[p];
    end
    @(negedge clk); vld = 1'b0; sof = 1'b0;
    if (do_eof) begin
      eof = 1'b1; good = g;
      @(negedge clk); eof = 1'b0; good = 1'b0;
    end
  endtask

  task automatic build(input int len, input logic mc);
    flen = len;
    for (int p = 0; p < len; p++) fb[p] = 8'($urandom);
    fb[0][0] = mc;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin
      s_msk[i] = '0; s_ofs[i] = '0; s_crc[i] = '0; s_en[i] = 0; s_mc[i] = 0;
    end
    exp_hit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "hit after reset", 32'(hit), 0);
    check("R1", "wake after reset", 32'(wake), 0);
    build(20, 1'b0);
    send(1'b1, 1'b1);
    check("R1", "no hit with reset config", 32'(hit), 0);

    // R2 R3 R4 basic match
    cfg(0, 32'h0000_0F0F, 32'h1, 8'd6, 16'h0);
    cfg(0, 32'h0000_0F0F, 32'h1, 8'd6, tb_crc(s_msk[0], 8'd6));
    send(1'b1, 1'b1);
    check("R4", "basic match hit", 32'(hit), 32'h1);
    check("R10", "wake follows hit", 32'(wake), 1);
    clear_hits();
    check("R10", "hit after clear", 32'(hit), 0);
    check("R10", "wake after clear", 32'(wake), 0);
    fb[10] = ~fb[10];                       // offset+4, mask bit 4 clear
    send(1'b1, 1'b1);
    check("R2", "unselected byte ignored", 32'(hit), 32'h1);
    clear_hits();
    fb[6] = ~fb[6];                         // offset+0, selected
    send(1'b1, 1'b1);
    check("R3", "selected byte alters crc", 32'(hit), 0);

    // R5
    cfg(0, 32'h0000_0F0F, 32'h0, 8'd6, tb_crc(32'h0F0F, 8'd6));
    send(1'b1, 1'b1);
    check("R5", "disabled filter", 32'(hit), 0);

    // R6
    cfg(0, 32'h0000_0F0F, 32'h9, 8'd6, tb_crc(32'h0F0F, 8'd6));
    send(1'b1, 1'b1);
    check("R6", "mcast filter on ucast frame", 32'(hit), 0);
    fb[0][0] = 1'b1;
    cfg(0, 32'h0000_0F0F, 32'h9, 8'd6, tb_crc(32'h0F0F, 8'd6));
    send(1'b1, 1'b1);
    check("R6", "mcast filter on mcast frame", 32'(hit), 32'h1);
    clear_hits();

    // R7 reserved bits set
    fb[0][0] = 1'b0;
    cfg(1, 32'h8000_00F0, 32'h7, 8'd2, tb_crc(31'h0F0, 8'd2));
    send(1'b1, 1'b1);
    check("R7", "reserved bits ignored", 32'(hit), 32'h2);
    clear_hits();

    // R8 incomplete frame, crc matches available bytes
    cfg(1, 32'h4000_0001, 32'h1, 8'd0, tb_crc(31'h4000_0001, 8'd0));
    send(1'b1, 1'b1);
    check("R8", "frame too short", 32'(hit), 0);

    // R9 bad end of frame
    cfg(1, 32'h0000_0003, 32'h1, 8'd4, tb_crc(31'h3, 8'd4));
    send(1'b0, 1'b1);
    check("R9", "bad eof no hit", 32'(hit), 0);
    check("R9", "bad eof no wake", 32'(wake), 0);

    // R10 clear wins over simultaneous good eof
    for (int p = 0; p < flen; p++) begin
      @(negedge clk); vld = 1'b1; sof = (p == 0); bdat = fb[p];
    end
    @(negedge clk); vld = 1'b0; sof = 1'b0; eof = 1'b1; good = 1'b1;
    we = 1'b1; addr = 5'd16; wdat = '0;
    @(negedge clk); eof = 1'b0; good = 1'b0; we = 1'b0;
    check("R10", "clear beats eof", 32'(hit), 0);

    // R12 aborted frame then restart; R10 sticky accumulation
    send(1'b1, 1'b1);
    check("R10", "filter1 hit", 32'(hit), 32'h2);
    begin
      logic [7:0] sv [0:127];
      int sl;
      for (int p = 0; p < 128; p++) sv[p] = fb[p];
      sl = flen;
      build(9, 1'b0);
      send(1'b1, 1'b0);                     // no end strobe
      for (int p = 0; p < 128; p++) fb[p] = sv[p];
      flen = sl;
    end
    cfg(3, 32'h0000_0055, 32'h1, 8'd1, tb_crc(31'h55, 8'd1));
    send(1'b1, 1'b1);
    check("R12", "restart after abort, sticky", 32'(hit), 32'hA);
    clear_hits();

    // random
    for (int it = 0; it < 60; it++) begin
      logic [3:0] h;
      build($urandom_range(1, 64), 1'($urandom));
      for (int i = 0; i < 4; i++) begin
        logic [31:0] m, cmd;
        logic [7:0] o;
        logic [15:0] c;
        m   = $urandom & $urandom & $urandom;
        o   = 8'($urandom_range(0, 16));
        cmd = {28'd0, ($urandom_range(0, 3) != 0) ? fb[0][0] : ~fb[0][0],
               2'($urandom), ($urandom_range(0, 4) != 0)};
        c   = ($urandom_range(0, 1) != 0) ? tb_crc(m[30:0], o) : 16'($urandom);
        cfg(i, m, cmd, o, c);
      end
      clear_hits();
      send(1'b1, 1'b1);
      h = model_hits();
      check("R4", "random hits", 32'(hit), 32'(h));
      check("R10", "random wake", 32'(wake), 32'(|h));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule